// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block sits on the bus side of a processor core and keeps a small byte queue topped up with the instruction bytes that lie ahead of execution. It holds the current code segment and fetch offset. From them it forms a 20-bit physical address, which is the segment shifted left by four plus the offset. It then reads whole aligned 16-bit words over a simple request/acknowledge memory port. The execution side takes bytes one at a time from a pop port at its own pace. Fetching and consuming overlap, so the queue forms the boundary of a two-stage pipeline.

When a control transfer happens, the execution side issues a redirect carrying a new segment and offset. The queue is emptied at once and fetching resumes from the new location. A word read that is still outstanding at that moment is allowed to finish on the bus, but its data is thrown away. A fetch that starts at an odd address reads the enclosing aligned word and keeps only its upper byte, so the stream realigns to even words after one step.

Top module: `ifq_unit`

## Requirements
- R1: During and after reset the pop port shows no valid byte. The first memory request after reset uses physical address 0xFFFF0, which is segment 0xFFFF with offset 0x0000.
- R2: The fetch address is segment*16 + offset. It is placed on `mem_addr` with bit 0 forced to 0, so every request names an aligned 16-bit word.
- R3: A request stays asserted with an unchanged address until the cycle in which `mem_ack` is high. Read data is taken in that cycle, and at most one request is outstanding.
- R4: A new request starts only when at least two of the six byte slots are free. With no pops, the queue settles at 6 bytes after an even start and at 5 bytes after an odd start, and the request line then stays low.
- R5: For an even fetch address, `mem_rdata[7:0]` is queued first, then `mem_rdata[15:8]`, and the offset advances by 2.
- R6: For an odd fetch address, only `mem_rdata[15:8]` is queued and the offset advances by 1.
- R7: `pop_byte` shows the oldest queued byte whenever `pop_valid` is high. The byte is removed on a cycle with `pop_ready` and `pop_valid` both high. A push and a pop may happen in the same cycle, and bytes leave in the order of their physical addresses.
- R8: A cycle with `redir_valid` high empties the queue, so `pop_valid` is low in the next cycle. It also loads the new segment and offset, and the next fetch uses them.
- R9: When a redirect occurs while a request is outstanding, the word returned for that request is discarded. This holds even when the acknowledge arrives in the same cycle as the redirect.
- R10: The offset wraps modulo 2^16 and the physical address wraps modulo 2^20. For example, segment 0xFFFF with offset 0xFFF2 fetches from 0x0FFE2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| redir_valid | input | 1 | Redirect command: flush the queue and load a new fetch location |
| redir_seg | input | 16 | Code segment for the redirect |
| redir_off | input | 16 | Instruction offset for the redirect |
| mem_req | output | 1 | Word read request to memory |
| mem_addr | output | 20 | Aligned physical word address of the request |
| mem_ack | input | 1 | Memory acknowledge; read data valid in this cycle |
| mem_rdata | input | 16 | Read data, low byte at the even address |
| pop_valid | output | 1 | Queue holds at least one byte |
| pop_byte | output | 8 | Oldest queued instruction byte |
| pop_ready | input | 1 | Execution side takes the byte shown |

## Verification
The memory model returns a byte value computed from each byte's own physical address. Every popped byte therefore shows both where it was fetched from and whether its lane was picked correctly. Straight-line runs from the reset location, with zero and non-zero memory latency and with pops continuous or withheld, separate correct ordering and simultaneous push/pop from lost or repeated bytes. Even and odd starting offsets, together with a drain that holds memory back, show the exact queue occupancy and which lane is kept. Redirects placed mid-wait and on the acknowledge cycle, and locations that cross the 16-bit offset and 20-bit address wrap, show whether stale words are dropped and whether addresses are formed correctly.

// File: rtl/ifq_pkg.sv
// Shared types for the instruction prefetch queue.
// Assumes byte-addressed memory read as 16-bit little-endian words.
package ifq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // number of byte lanes in one bus word
    localparam int unsigned IFQ_LANES  = 2;
    // width of one bus word
    localparam int unsigned IFQ_WORD_W = 8 * IFQ_LANES;

    typedef logic [7:0] ifq_byte_t;

    // fetch controller: no request open, or waiting for acknowledge
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_WAIT = 1'b1
    } ifq_fstate_e;
endpackage

// File: rtl/ifq_addr_gen.sv
// Physical address former: segment shifted left by SEG_SHIFT plus offset,
// truncated to ADDR_W bits (wraps modulo 2^ADDR_W).
// Assumes SEG_W + SEG_SHIFT <= ADDR_W and OFF_W <= ADDR_W.
module ifq_addr_gen #(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned SEG_W     = 16,
    parameter int unsigned OFF_W     = 16,
    parameter int unsigned SEG_SHIFT = 4
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] phys
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned SEG_PAD = ADDR_W - SEG_W - SEG_SHIFT;
    localparam int unsigned OFF_PAD = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] seg_base;
    logic [ADDR_W-1:0] off_ext;

    // widen the segment into a base address and the offset to full width
    generate
        if (SEG_PAD > 0) begin : g_seg_pad
            assign seg_base = {{SEG_PAD{1'b0}}, seg, {SEG_SHIFT{1'b0}}};
        end else begin : g_seg_nopad
            assign seg_base = {seg, {SEG_SHIFT{1'b0}}};
        end
        if (OFF_PAD > 0) begin : g_off_pad
            assign off_ext = {{OFF_PAD{1'b0}}, off};
        end else begin : g_off_nopad
            assign off_ext = off;
        end
    endgenerate

    // sum wraps naturally at ADDR_W bits
    always_comb begin
        phys = seg_base + off_ext;
    end
endmodule

// File: rtl/ifq_byte_queue.sv
// Circular byte queue of DEPTH entries. Accepts zero, one or two bytes per
// cycle and releases one byte per cycle; push and pop may coincide.
// Flush empties it and takes priority. Assumes the producer never pushes
// more bytes than free_slots plus the byte popped in the same cycle.
module ifq_byte_queue
    import ifq_pkg::*;
#(
    parameter int unsigned DEPTH = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic [1:0]                 push_cnt,
    input  ifq_byte_t                  push_b0,
    input  ifq_byte_t                  push_b1,
    input  logic                       pop_req,
    output logic                       pop_valid,
    output ifq_byte_t                  pop_byte,
    output logic [$clog2(DEPTH+1)-1:0] free_slots
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    ifq_byte_t        slot_q [DEPTH];
    logic [PTR_W-1:0] rd_q;
    logic [PTR_W-1:0] wr_q;
    logic [PTR_W-1:0] wr_nx1;
    logic [PTR_W-1:0] wr_nx2;
    logic [CNT_W-1:0] count_q;
    logic             pop_fire;

    // advance a pointer by one, wrapping at DEPTH
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // derive pointer neighbours and handshake terms
    always_comb begin
        wr_nx1     = bump(wr_q);
        wr_nx2     = bump(wr_nx1);
        pop_valid  = (count_q != '0);
        pop_fire   = pop_req && pop_valid;
        pop_byte   = slot_q[rd_q];
        free_slots = CNT_W'(DEPTH) - count_q;
    end

    // write incoming bytes into their slots
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!flush && push_cnt != 2'd0 && wr_q == PTR_W'(i)) begin
                slot_q[i] <= push_b0;
            end else if (!flush && push_cnt == 2'd2 && wr_nx1 == PTR_W'(i)) begin
                slot_q[i] <= push_b1;
            end
        end
    end

    // maintain read/write pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q    <= '0;
            wr_q    <= '0;
            count_q <= '0;
        end else begin
            if (pop_fire) begin
                rd_q <= bump(rd_q);
            end
            case (push_cnt)
                2'd1:    wr_q <= wr_nx1;
                2'd2:    wr_q <= wr_nx2;
                default: wr_q <= wr_q;
            endcase
            count_q <= count_q + CNT_W'(push_cnt) - CNT_W'(pop_fire);
        end
    end

    // R4: occupancy never passes the queue size
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R4: the producer only pushes what fits
    p_push_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_cnt != 2'd0 && !flush) |->
            ({1'b0, free_slots} + (CNT_W+1)'(pop_fire)) >= (CNT_W+1)'(push_cnt));
endmodule

// File: rtl/ifq_fetch_ctrl.sv
// Fetch controller: holds segment and offset, opens one aligned word read
// at a time when the queue has room for a full word, steers the useful
// byte lanes into the queue and discards words made stale by a redirect.
// Assumes the memory holds request data valid only in the acknowledge cycle.
module ifq_fetch_ctrl
    import ifq_pkg::*;
#(
    parameter int unsigned    ADDR_W    = 20,
    parameter int unsigned    SEG_W     = 16,
    parameter int unsigned    OFF_W     = 16,
    parameter int unsigned    SEG_SHIFT = 4,
    parameter int unsigned    QDEPTH    = 6,
    parameter logic [SEG_W-1:0] RESET_SEG = '1,
    parameter logic [OFF_W-1:0] RESET_OFF = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        redir_valid,
    input  logic [SEG_W-1:0]            redir_seg,
    input  logic [OFF_W-1:0]            redir_off,
    input  logic [$clog2(QDEPTH+1)-1:0] free_slots,
    output logic                        mem_req,
    output logic [ADDR_W-1:0]           mem_addr,
    input  logic                        mem_ack,
    input  logic [IFQ_WORD_W-1:0]       mem_rdata,
    output logic [1:0]                  push_cnt,
    output ifq_byte_t                   push_b0,
    output ifq_byte_t                   push_b1
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned CNT_W = $clog2(QDEPTH + 1);

    ifq_fstate_e       state_q;
    logic [SEG_W-1:0]  seg_q;
    logic [OFF_W-1:0]  off_q;
    logic [ADDR_W-1:0] addr_q;
    logic              odd_q;
    logic              drop_q;
    logic [ADDR_W-1:0] fetch_phys;
    logic              issue;
    logic              deliver;
    ifq_byte_t         lane [IFQ_LANES];

    ifq_addr_gen #(
        .ADDR_W    (ADDR_W),
        .SEG_W     (SEG_W),
        .OFF_W     (OFF_W),
        .SEG_SHIFT (SEG_SHIFT)
    ) u_agen (
        .seg  (seg_q),
        .off  (off_q),
        .phys (fetch_phys)
    );

    // split the returned word into byte lanes
    generate
        for (genvar g = 0; g < IFQ_LANES; g++) begin : g_lane
            assign lane[g] = mem_rdata[8*g +: 8];
        end
    endgenerate

    // decide when to open a request and when returned data is kept
    always_comb begin
        issue   = (state_q == FS_IDLE) && !redir_valid
                  && (free_slots >= CNT_W'(IFQ_LANES));
        deliver = (state_q == FS_WAIT) && mem_ack && !drop_q && !redir_valid;
        mem_req  = (state_q == FS_WAIT);
        mem_addr = addr_q;
    end

    // select the bytes handed to the queue
    always_comb begin
        push_cnt = 2'd0;
        push_b0  = lane[0];
        push_b1  = lane[1];
        if (deliver) begin
            if (odd_q) begin
                push_cnt = 2'd1;
                push_b0  = lane[1];
            end else begin
                push_cnt = 2'd2;
            end
        end
    end

    // track the fetch location: redirect loads it, a kept word advances it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= RESET_SEG;
            off_q <= RESET_OFF;
        end else if (redir_valid) begin
            seg_q <= redir_seg;
            off_q <= redir_off;
        end else if (deliver) begin
            off_q <= off_q + (odd_q ? OFF_W'(1) : OFF_W'(2));
        end
    end

    // request state machine with stale-data marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            addr_q  <= '0;
            odd_q   <= 1'b0;
            drop_q  <= 1'b0;
        end else begin
            case (state_q)
                FS_IDLE: begin
                    if (issue) begin
                        state_q <= FS_WAIT;
                        addr_q  <= {fetch_phys[ADDR_W-1:1], 1'b0};
                        odd_q   <= fetch_phys[0];
                        drop_q  <= 1'b0;
                    end
                end
                FS_WAIT: begin
                    if (mem_ack) begin
                        state_q <= FS_IDLE;
                        drop_q  <= 1'b0;
                    end else if (redir_valid) begin
                        drop_q  <= 1'b1;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // R3: an open request holds its address until acknowledged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R3: a request closes once acknowledged (one outstanding)
    p_one_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // R2: every request names an aligned word
    p_even_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    // R4: a request only opens when a whole word fits
    p_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> ($past(free_slots) >= CNT_W'(IFQ_LANES)));
endmodule

// File: rtl/ifq_unit.sv
// Instruction prefetch queue unit: ties the fetch controller to the byte
// queue and exposes the memory request port and the execution pop port.
// Assumes a single requester on the memory port and a 16-bit data path.
module ifq_unit
    import ifq_pkg::*;
#(
    parameter int unsigned    ADDR_W    = 20,
    parameter int unsigned    SEG_W     = 16,
    parameter int unsigned    OFF_W     = 16,
    parameter int unsigned    SEG_SHIFT = 4,
    parameter int unsigned    QDEPTH    = 6,
    parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
    parameter logic [OFF_W-1:0] RESET_OFF = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redir_valid,
    input  logic [SEG_W-1:0]  redir_seg,
    input  logic [OFF_W-1:0]  redir_off,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    output logic              pop_valid,
    output logic [7:0]        pop_byte,
    input  logic              pop_ready
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned CNT_W = $clog2(QDEPTH + 1);

    logic [CNT_W-1:0] free_slots;
    logic [1:0]       push_cnt;
    ifq_byte_t        push_b0;
    ifq_byte_t        push_b1;

    ifq_fetch_ctrl #(
        .ADDR_W    (ADDR_W),
        .SEG_W     (SEG_W),
        .OFF_W     (OFF_W),
        .SEG_SHIFT (SEG_SHIFT),
        .QDEPTH    (QDEPTH),
        .RESET_SEG (RESET_SEG),
        .RESET_OFF (RESET_OFF)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .redir_valid (redir_valid),
        .redir_seg   (redir_seg),
        .redir_off   (redir_off),
        .free_slots  (free_slots),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .push_cnt    (push_cnt),
        .push_b0     (push_b0),
        .push_b1     (push_b1)
    );

    ifq_byte_queue #(
        .DEPTH (QDEPTH)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (redir_valid),
        .push_cnt   (push_cnt),
        .push_b0    (push_b0),
        .push_b1    (push_b1),
        .pop_req    (pop_ready),
        .pop_valid  (pop_valid),
        .pop_byte   (pop_byte),
        .free_slots (free_slots)
    );

    // R8: the cycle after a redirect the pop port is empty
    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !pop_valid);

    // R9: no bytes are pushed while a redirect is taking effect
    p_stale_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && mem_ack) |-> (push_cnt == 2'd0));
endmodule

// File: tb/sim_ifq_unit.sv
// Directed bench for ifq_unit: a memory model whose byte values encode
// their own address, and one task per scenario.
module sim_ifq_unit;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redir_valid = 1'b0;
    logic [15:0] redir_seg = '0;
    logic [15:0] redir_off = '0;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        pop_ready = 1'b0;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        pop_valid;
    logic [7:0]  pop_byte;

    int          tests = 0;
    int          fails = 0;
    int          lat = 0;
    int          req_seen = 0;
    logic [19:0] last_req = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    ifq_unit u0 (
        .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid),
        .redir_seg(redir_seg), .redir_off(redir_off),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .pop_valid(pop_valid), .pop_byte(pop_byte),
        .pop_ready(pop_ready)
    );

    function automatic logic [7:0] mbyte(input logic [19:0] a);
        return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // memory model: acks after lat waiting cycles, checks request hold
    initial begin
        int          wcnt;
        bit          pend;
        logic [19:0] held;
        wcnt = 0; pend = 0; held = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req && rst_n) begin
                if (pend) begin
                    check(mem_addr == held, "R3", "address held", mem_addr, held);
                end else begin
                    pend = 1; held = mem_addr; wcnt = 0;
                    req_seen++; last_req = mem_addr;
                    check(mem_addr[0] == 1'b0, "R2", "aligned request", mem_addr, {mem_addr[19:1], 1'b0});
                end
                if (wcnt >= lat) begin
                    mem_ack = 1'b1;
                    mem_rdata = {mbyte({held[19:1], 1'b1}), mbyte({held[19:1], 1'b0})};
                    pend = 0;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // pop n bytes expected from location s:o; call at a negedge
    task automatic pop_expect(input logic [15:0] s, input logic [15:0] o,
                              input int n, input string rq);
        for (int k = 0; k < n; k++) begin
            logic [7:0] exp;
            exp = mbyte(phys(s, o + 16'(k)));
            while (!pop_valid) @(negedge clk);
            check(pop_byte == exp, rq, "popped byte", pop_byte, exp);
            pop_ready = 1'b1;
            @(negedge clk);
            pop_ready = 1'b0;
        end
    endtask

    // redirect at a negedge and confirm the queue is empty afterwards
    task automatic redirect(input logic [15:0] s, input logic [15:0] o);
        redir_seg = s; redir_off = o; redir_valid = 1'b1;
        @(negedge clk);
        redir_valid = 1'b0;
        check(!pop_valid, "R8", "empty after redirect", pop_valid, 0);
    endtask

    // with memory held back, pop everything queued and count it
    task automatic drain_count(input logic [15:0] s, input logic [15:0] o,
                               input int expn, input string rq);
        int k;
        k = 0;
        lat = 60;
        while (pop_valid) begin
            check(pop_byte == mbyte(phys(s, o + 16'(k))), rq, "drained byte",
                  pop_byte, mbyte(phys(s, o + 16'(k))));
            pop_ready = 1'b1;
            @(negedge clk);
            pop_ready = 1'b0;
            k++;
        end
        check(k == expn, "R4", "settled occupancy", k, expn);
        lat = 0;
        repeat (80) @(negedge clk);
    endtask

    task automatic t_reset();
        int c0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(!pop_valid, "R1", "pop_valid in reset", pop_valid, 0);
        check(!mem_req, "R1", "no request in reset", mem_req, 0);
        c0 = req_seen;
        rst_n = 1'b1;
        while (req_seen == c0) @(negedge clk);
        check(last_req == 20'hFFFF0, "R1", "first fetch address", last_req, 20'hFFFF0);
        // straight run crossing the top of the address space
        pop_expect(16'hFFFF, 16'h0000, 24, "R5 R7 R10");
    endtask

    task automatic t_fill_even();
        redirect(16'h0100, 16'h0020);
        repeat (30) @(negedge clk);
        check(!mem_req, "R4", "idle when full", mem_req, 0);
        drain_count(16'h0100, 16'h0020, 6, "R5");
    endtask

    task automatic t_odd();
        int c0;
        redirect(16'h1234, 16'h0011);
        c0 = req_seen;
        while (req_seen == c0) @(negedge clk);
        check(last_req == 20'h12350, "R2", "odd start word", last_req, 20'h12350);
        repeat (30) @(negedge clk);
        check(!mem_req, "R4", "idle at five bytes", mem_req, 0);
        drain_count(16'h1234, 16'h0011, 5, "R6");
    endtask

    task automatic t_wrap();
        int c0;
        redirect(16'hFFFF, 16'hFFF2);
        c0 = req_seen;
        while (req_seen == c0) @(negedge clk);
        check(last_req == 20'h0FFE2, "R10", "20-bit wrap", last_req, 20'h0FFE2);
        pop_expect(16'hFFFF, 16'hFFF2, 8, "R10");
        redirect(16'h2000, 16'hFFFD);
        pop_expect(16'h2000, 16'hFFFD, 7, "R10 R6");
    endtask

    task automatic t_drop_wait();
        int c0;
        lat = 6;
        redirect(16'h3000, 16'h0004);
        c0 = req_seen;
        while (req_seen == c0) @(negedge clk);
        @(negedge clk);
        redirect(16'h4000, 16'h0007);
        pop_expect(16'h4000, 16'h0007, 6, "R9");
        lat = 0;
    endtask

    task automatic t_drop_ack();
        lat = 3;
        redirect(16'h5000, 16'h0000);
        @(posedge mem_ack);
        redirect(16'h6000, 16'h0009);
        lat = 0;
        pop_expect(16'h6000, 16'h0009, 6, "R9");
    endtask

    task automatic t_steady();
        lat = 2;
        redirect(16'h0777, 16'h0003);
        pop_expect(16'h0777, 16'h0003, 16, "R7 R3");
        lat = 0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fill_even();
        t_odd();
        t_wrap();
        t_drop_wait();
        t_drop_ack();
        t_steady();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R7 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule